// File: doc/BRIEF.md
# Lane-Partitioned Wide Integer ALU with Selective Commit

This block is the execute-stage arithmetic unit of a wide-register datapath. It takes two 256-bit operands and treats them as a packed vector of bytes, halfwords or words. A 2-bit element-size selector picks the view. The block applies one operation to every element at once: add, subtract, a bitwise function, or a shift. No carry and no shifted bit ever crosses an element boundary.

Alongside the result, the block holds a set of per-byte condition flags (zero, negative, carry) and forms a 32-bit byte write-enable vector. Only the destination bytes flagged in that vector are committed by the register file. The write enables come from a 2-bit participation mode. That mode reads either the stored flags (a lane's own and its lower neighbour's) or a 32-bit lane mask. The same instruction can also ask for the flags to be refreshed. When it does, only participating bytes take the new flags, at the next rising clock edge. The result and the write enables are purely combinational within the cycle.

Top module: `simd_alu`

## Requirements
- R1: `wsel` selects the element size: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, and 11 is handled as 32-bit. Element k occupies bits [k*E +: E], and no carry, borrow or shifted bit passes between elements.
- R2: `funct` 0 gives a+b per element and `funct` 1 gives a-b per element, both modulo 2^E. The carry flag is the carry out of the element for add; for subtract it is 1 when a >= b unsigned, i.e. no borrow.
- R3: `funct` 2/3/4 give a AND b, a OR b and a XOR b. `funct` 5 gives NOT a. `funct` codes 9 to 15 give a zero result.
- R4: `funct` 6/7/8 shift each element of a left logically, right logically, or right arithmetically. The shift amount is the low log2(E) bits of the matching element of b.
- R5: The flags are per byte: zero = element result is 0, negative = element result MSB, carry as in R2 and 0 for all other functions. For 16- and 32-bit elements the element's flags are copied into every byte of the element.
- R6: With `upd_cc` = 0 the stored flags `zf`, `nf` and `cf` do not change.
- R7: With `upd_cc` = 1 the flags of bytes with `byte_wen` set take the new values at the rising clock edge. All other bytes keep theirs.
- R8: Participation mode 00 sets all 32 `byte_wen` bits.
- R9: Mode 01 enables an element when the stored zero flag of its most significant byte is 0.
- R10: Mode 10 enables element k when `lane_mask` bit k is 1.
- R11: Mode 11 enables an element when the stored zero flag of its own top byte is 1, or when the stored zero flag of the byte just below the element is 1. Element 0 has no lower neighbour, so that neighbour term is 0.
- R12: Every `byte_wen` bit of an element carries the element's enable. `byte_wen` is derived from the flags stored before the current edge.
- R13: An active-low reset clears all stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock for the flag store |
| rst_n | input | 1 | active-low asynchronous reset |
| opa | input | 256 | first operand |
| opb | input | 256 | second operand / per-element shift amount |
| funct | input | 4 | operation code |
| wsel | input | 2 | element size selector |
| upd_cc | input | 1 | request to refresh the flags |
| pmode | input | 2 | participation mode |
| lane_mask | input | 32 | per-element enable mask for mode 10 |
| result | output | 256 | full ALU result, all elements |
| byte_wen | output | 32 | per-byte commit enable |
| zf | output | 32 | stored per-byte zero flags |
| nf | output | 32 | stored per-byte negative flags |
| cf | output | 32 | stored per-byte carry flags |

## Verification
Two things can happen in the same cycle. Participation is decided from the stored zero flags, and the same instruction rewrites those flags, but only on the bytes it enables. The bench provokes this with back-to-back flag-updating instructions under modes 01 and 11 at every element size. Each instruction's write enables must match a bench model fed with the flags from before the edge. After the edge, the bytes left out must still hold their earlier flags while the enabled ones carry the new values.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_NOT = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_SAR = 4'd8
    } simd_op_e;

    typedef enum logic [1:0] {
        EW_B   = 2'd0,
        EW_H   = 2'd1,
        EW_W   = 2'd2,
        EW_RSV = 2'd3
    } simd_ew_e;

    typedef enum logic [1:0] {
        PM_ALL  = 2'd0,
        PM_NZ   = 2'd1,
        PM_MASK = 2'd2,
        PM_NBR  = 2'd3
    } simd_pm_e;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [3:0]    funct,
    output logic [EW-1:0] y,
    output logic          z,
    output logic          n,
    output logic          c
);
    localparam int SW = $clog2(EW);

    logic [SW-1:0] sh;
    logic [EW:0]   sum;

    assign sh = b[SW-1:0];

    always_comb begin
        sum = '0;
        c   = 1'b0;
        case (funct)
            OP_ADD: begin
                sum = {1'b0, a} + {1'b0, b};
                y   = sum[EW-1:0];
                c   = sum[EW];
            end
            OP_SUB: begin
                sum = {1'b0, a} + {1'b0, ~b} + (EW+1)'(1);
                y   = sum[EW-1:0];
                c   = sum[EW];
            end
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHL:  y = a << sh;
            OP_SHR:  y = a >> sh;
            OP_SAR:  y = EW'($signed(a) >>> sh);
            default: y = '0;
        endcase
    end

    assign z = (y == '0);
    assign n = y[EW-1];

endmodule

// File: rtl/simd_part.sv
module simd_part
    import simd_pkg::*;
#(
    parameter int NB = 32
) (
    input  logic [1:0]    pmode,
    input  logic [1:0]    wsel,
    input  logic [NB-1:0] zf_q,
    input  logic [NB-1:0] lane_mask,
    output logic [NB-1:0] byte_wen
);
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            int lg;
            int elem;
            int topb;
            logic own_z;
            logic nbr_z;
            case (simd_ew_e'(wsel))
                EW_B:    lg = 0;
                EW_H:    lg = 1;
                default: lg = 2;
            endcase
            elem  = j >> lg;
            topb  = ((elem + 1) << lg) - 1;
            own_z = zf_q[topb];
            nbr_z = (elem != 0) ? zf_q[(elem << lg) - 1] : 1'b0;
            case (simd_pm_e'(pmode))
                PM_ALL:  byte_wen[j] = 1'b1;
                PM_NZ:   byte_wen[j] = ~own_z;
                PM_MASK: byte_wen[j] = lane_mask[elem];
                default: byte_wen[j] = own_z | nbr_z;
            endcase
        end
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [3:0]      funct,
    input  logic [1:0]      wsel,
    input  logic            upd_cc,
    input  logic [1:0]      pmode,
    input  logic [DW/8-1:0] lane_mask,
    output logic [DW-1:0]   result,
    output logic [DW/8-1:0] byte_wen,
    output logic [DW/8-1:0] zf,
    output logic [DW/8-1:0] nf,
    output logic [DW/8-1:0] cf
);
    localparam int NB  = DW / 8;
    localparam int N16 = DW / 16;
    localparam int N32 = DW / 32;

    logic [DW-1:0]  y8, y16, y32;
    logic [NB-1:0]  z8, n8, c8;
    logic [N16-1:0] z16, n16, c16;
    logic [N32-1:0] z32, n32, c32;
    logic [NB-1:0]  z16b, n16b, c16b, z32b, n32b, c32b;
    logic [NB-1:0]  z_new, n_new, c_new;
    logic [NB-1:0]  zf_q, nf_q, cf_q;

    for (genvar i = 0; i < NB; i++) begin : g_b
        simd_lane #(.EW(8)) u_lane (
            .a(opa[8*i +: 8]), .b(opb[8*i +: 8]), .funct(funct),
            .y(y8[8*i +: 8]), .z(z8[i]), .n(n8[i]), .c(c8[i])
        );
    end

    for (genvar i = 0; i < N16; i++) begin : g_h
        simd_lane #(.EW(16)) u_lane (
            .a(opa[16*i +: 16]), .b(opb[16*i +: 16]), .funct(funct),
            .y(y16[16*i +: 16]), .z(z16[i]), .n(n16[i]), .c(c16[i])
        );
    end

    for (genvar i = 0; i < N32; i++) begin : g_w
        simd_lane #(.EW(32)) u_lane (
            .a(opa[32*i +: 32]), .b(opb[32*i +: 32]), .funct(funct),
            .y(y32[32*i +: 32]), .z(z32[i]), .n(n32[i]), .c(c32[i])
        );
    end

    // Copy each wide element's flags into all of its bytes
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            z16b[j] = z16[j/2];
            n16b[j] = n16[j/2];
            c16b[j] = c16[j/2];
            z32b[j] = z32[j/4];
            n32b[j] = n32[j/4];
            c32b[j] = c32[j/4];
        end
    end

    always_comb begin
        case (simd_ew_e'(wsel))
            EW_B: begin
                result = y8;
                z_new  = z8;
                n_new  = n8;
                c_new  = c8;
            end
            EW_H: begin
                result = y16;
                z_new  = z16b;
                n_new  = n16b;
                c_new  = c16b;
            end
            default: begin
                result = y32;
                z_new  = z32b;
                n_new  = n32b;
                c_new  = c32b;
            end
        endcase
    end

    simd_part #(.NB(NB)) u_part (
        .pmode(pmode), .wsel(wsel), .zf_q(zf_q),
        .lane_mask(lane_mask), .byte_wen(byte_wen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zf_q <= '0;
            nf_q <= '0;
            cf_q <= '0;
        end else if (upd_cc) begin
            zf_q <= (zf_q & ~byte_wen) | (z_new & byte_wen);
            nf_q <= (nf_q & ~byte_wen) | (n_new & byte_wen);
            cf_q <= (cf_q & ~byte_wen) | (c_new & byte_wen);
        end
    end

    assign zf = zf_q;
    assign nf = nf_q;
    assign cf = cf_q;

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DW = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   opa,
    input logic [3:0]      funct,
    input logic [1:0]      wsel,
    input logic            upd_cc,
    input logic [1:0]      pmode,
    input logic [DW/8-1:0] lane_mask,
    input logic [DW/8-1:0] byte_wen,
    input logic [DW/8-1:0] zf,
    input logic [DW/8-1:0] nf,
    input logic [DW/8-1:0] cf
);
    localparam int NB = DW / 8;
    localparam logic [NB-1:0] EVEN = {(NB/2){2'b01}};

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_cc |=> ($stable(zf) && $stable(nf) && $stable(cf)));

    a_r7_gated_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_cc |=> ((((zf ^ $past(zf)) | (nf ^ $past(nf)) | (cf ^ $past(cf)))
                     & ~$past(byte_wen)) == '0));

    a_r8_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == 2'd0) |-> (byte_wen == '1));

    a_r10_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == 2'd2 && wsel == 2'd0) |-> (byte_wen == lane_mask));

    a_r12_half_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel == 2'd1) |-> (((byte_wen >> 1) & EVEN) == (byte_wen & EVEN)));

    a_r5_zero_after_and: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cc && pmode == 2'd0 && funct == 4'd2 && opa == '0)
        |=> (zf == '1 && nf == '0 && cf == '0));

endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .opa(opa), .funct(funct), .wsel(wsel),
    .upd_cc(upd_cc), .pmode(pmode), .lane_mask(lane_mask),
    .byte_wen(byte_wen), .zf(zf), .nf(nf), .cf(cf)
);

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] opa = '0, opb = '0;
    logic [3:0]   funct = '0;
    logic [1:0]   wsel = '0;
    logic         upd_cc = 1'b0;
    logic [1:0]   pmode = '0;
    logic [31:0]  lane_mask = '0;
    logic [255:0] result;
    logic [31:0]  byte_wen, zf, nf, cf;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] mz = '0, mn = '0, mc = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    simd_alu dut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .funct(funct),
        .wsel(wsel), .upd_cc(upd_cc), .pmode(pmode), .lane_mask(lane_mask),
        .result(result), .byte_wen(byte_wen), .zf(zf), .nf(nf), .cf(cf)
    );

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = nxt();
        return v;
    endfunction

    // Reference ALU built from the requirement text
    function automatic void model(input logic [255:0] a, input logic [255:0] b,
                                  input logic [3:0] f, input logic [1:0] w,
                                  output logic [255:0] y, output logic [31:0] z,
                                  output logic [31:0] n, output logic [31:0] c);
        int ewb, ew, sh;
        logic [32:0] m, ea, eb, s, r;
        logic [255:0] ta, tb;
        logic cy;
        ewb = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        ew  = 8 * ewb;
        m   = (33'd1 << ew) - 33'd1;
        y = '0; z = '0; n = '0; c = '0;
        for (int e = 0; e < 32 / ewb; e++) begin
            ta = a >> (e * ew);
            tb = b >> (e * ew);
            ea = {1'b0, ta[31:0]} & m;
            eb = {1'b0, tb[31:0]} & m;
            sh = int'(eb[4:0]) & (ew - 1);
            cy = 1'b0;
            s  = '0;
            case (f)
                4'd0: begin s = ea + eb; r = s & m; cy = s[ew]; end
                4'd1: begin s = ea + (~eb & m) + 33'd1; r = s & m; cy = s[ew]; end
                4'd2: r = ea & eb;
                4'd3: r = ea | eb;
                4'd4: r = ea ^ eb;
                4'd5: r = ~ea & m;
                4'd6: r = (ea << sh) & m;
                4'd7: r = ea >> sh;
                4'd8: r = (ea >> sh) | (ea[ew-1] ? (m & ~(m >> sh)) : 33'd0);
                default: r = '0;
            endcase
            y = y | ({223'b0, r} << (e * ew));
            for (int k = 0; k < ewb; k++) begin
                z[e*ewb + k] = (r == 33'd0);
                n[e*ewb + k] = r[ew-1];
                c[e*ewb + k] = cy;
            end
        end
    endfunction

    function automatic logic [31:0] exp_wen(input logic [1:0] pm, input logic [1:0] w,
                                            input logic [31:0] mk, input logic [31:0] zq);
        logic [31:0] v;
        int lg, el;
        lg = (w == 2'd0) ? 0 : (w == 2'd1) ? 1 : 2;
        for (int j = 0; j < 32; j++) begin
            logic own, nb;
            el  = j >> lg;
            own = zq[((el + 1) << lg) - 1];
            nb  = (el != 0) ? zq[(el << lg) - 1] : 1'b0;
            case (pm)
                2'd0: v[j] = 1'b1;
                2'd1: v[j] = ~own;
                2'd2: v[j] = mk[el];
                default: v[j] = own | nb;
            endcase
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One instruction: drive, check combinational outputs, clock, check flags
    task automatic step(input logic [255:0] a, input logic [255:0] b, input logic [3:0] f,
                        input logic [1:0] w, input logic u, input logic [1:0] pm,
                        input logic [31:0] mk, input string tag);
        logic [255:0] ey;
        logic [31:0] ez, en, ec, ew_v;
        opa = a; opb = b; funct = f; wsel = w; upd_cc = u; pmode = pm; lane_mask = mk;
        #1;
        model(a, b, f, w, ey, ez, en, ec);
        ew_v = exp_wen(pm, w, mk, mz);
        check(result === ey, {tag, " result"}, result, ey);
        check(byte_wen === ew_v, "R8 R9 R10 R11 R12 byte_wen", {224'b0, byte_wen}, {224'b0, ew_v});
        if (u) begin
            mz = (mz & ~ew_v) | (ez & ew_v);
            mn = (mn & ~ew_v) | (en & ew_v);
            mc = (mc & ~ew_v) | (ec & ew_v);
        end
        @(negedge clk);
        check({zf, nf, cf} === {mz, mn, mc}, u ? "R5 R7 flags" : "R6 flags held",
              {160'b0, zf, nf, cf}, {160'b0, mz, mn, mc});
    endtask

    task automatic t_reset();
        check({zf, nf, cf} === 96'b0, "R13 reset flags", {160'b0, zf, nf, cf}, '0);
        step('0, '0, 4'd2, 2'd0, 1'b0, 2'd3, '0, "R13 R11 reset nbr");
        step('0, '0, 4'd2, 2'd2, 1'b0, 2'd1, '0, "R13 R9 reset nz");
    endtask

    task automatic t_arith();
        for (int w = 0; w < 4; w++) begin
            step({32{8'hFF}}, {32{8'h01}}, 4'd0, 2'(w), 1'b1, 2'd0, '0, "R1 R2 add carry");
            step({32{8'h10}}, {32{8'h11}}, 4'd1, 2'(w), 1'b1, 2'd0, '0, "R1 R2 sub borrow");
            step(rnd256(), rnd256(), 4'd0, 2'(w), 1'b1, 2'd0, '0, "R1 R2 add rnd");
            step(rnd256(), rnd256(), 4'd1, 2'(w), 1'b1, 2'd0, '0, "R1 R2 sub rnd");
        end
    endtask

    task automatic t_logic();
        for (int f = 2; f < 6; f++)
            step(rnd256(), rnd256(), 4'(f), 2'd1, 1'b1, 2'd0, '0, "R3 R5 logic");
        step(rnd256(), rnd256(), 4'd9, 2'd0, 1'b1, 2'd0, '0, "R3 unused code");
        step(rnd256(), rnd256(), 4'd15, 2'd2, 1'b0, 2'd0, '0, "R3 unused code");
        step('0, rnd256(), 4'd2, 2'd2, 1'b1, 2'd0, '0, "R3 R5 and zero");
    endtask

    task automatic t_shift();
        for (int w = 0; w < 4; w++)
            for (int f = 6; f < 9; f++) begin
                step(rnd256(), rnd256(), 4'(f), 2'(w), 1'b1, 2'd0, '0, "R4 shift rnd");
                step({32{8'h81}}, {8{32'h0000_0021}}, 4'(f), 2'(w), 1'b1, 2'd0, '0,
                     "R4 shift wrap");
            end
    endtask

    task automatic t_hold();
        step(rnd256(), rnd256(), 4'd0, 2'd0, 1'b1, 2'd0, '0, "R5 seed");
        step('0, '0, 4'd2, 2'd0, 1'b0, 2'd0, '0, "R6 no update");
        step({32{8'hFF}}, {32{8'h01}}, 4'd0, 2'd2, 1'b0, 2'd0, '0, "R6 no update");
    endtask

    task automatic t_modes();
        for (int w = 0; w < 4; w++)
            for (int pm = 1; pm < 4; pm++) begin
                logic [255:0] a;
                a = rnd256();
                for (int i = 0; i < 32; i++) if (nxt() < 32'h6000_0000) a[8*i +: 8] = 8'h00;
                step(a, rnd256(), 4'd2, 2'(w), 1'b1, 2'(pm), nxt(), "R7 R9 R10 R11 modes");
                step(rnd256(), rnd256(), 4'd1, 2'(w), 1'b1, 2'(pm), nxt(), "R7 R12 modes");
            end
        step(rnd256(), rnd256(), 4'd0, 2'd0, 1'b1, 2'd2, 32'hA5C3_0F01, "R10 R7 byte mask");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_shift();
        t_hold();
        t_modes();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule